// File: doc/BRIEF.md
# Dispatch Steering Unit

Each cycle this block takes a group of up to `W` renamed instructions from the rename stage, along with a count of how many slots are valid. It walks the valid slots in program order and decides where each one goes. The choices are the out-of-order instruction queue, the load/store queue, the non-speculative queue, or a direct "advance tail" path. The direct path marks a slot issued and ready to commit without scheduling it. A store goes to two places at once. A load is likewise written to both the instruction queue and the load/store queue.

Every slot that is not squashed claims one instruction-queue entry. The block compares these claims with the free-entry count that comes back from the queue. When a slot finds no entry left, the walk stops at that slot. The block then raises a stall to rename and flags that slot, together with every later valid slot, in a replay mask, so that upstream can hold those slots and present them again.

Six event counters record squashed drops, full events, general dispatches, loads, stores and non-speculative dispatches. All counters are registered and reset synchronously.

Top module: `dispatch_steer`

## Requirements
- R1: After a cycle with `rst` high, all six counters read zero.
- R2: Only slots with index below `grp_count` are considered. A slot at or above the count raises no push, mark, tail or replay bit, whatever its flags.
- R3: A valid squashed slot (flag bit 0) produces no output bits and claims no queue entry. It adds one to `cnt_squashed` at the next clock edge, unless the walk already stopped before it.
- R4: A non-squashed valid slot that finds the number of entries claimed so far equal to `iq_free` raises `stall`. That slot and every later valid slot set their `replay` bits and produce no other outputs. `cnt_full` grows by exactly one at the next edge, and `stall` low means `replay` is all zero.
- R5: A load (flag bit 1) sets both `push_lsq` and `push_iq`, and adds one to both `cnt_load` and `cnt_dispatched`.
- R6: A store (flag bit 2) sets `push_lsq`, `push_nsq` and `can_commit`, and adds one to both `cnt_store` and `cnt_nonspec`.
- R7: A non-speculative slot (flag bit 3) sets only `push_nsq` and adds one to `cnt_nonspec`.
- R8: A nop (flag bit 4) or an already-executed slot (flag bit 5) sets `mark_issued`, `can_commit` and `tail_adv`, and moves no counter.
- R9: A slot with none of flag bits 0 to 5 set raises only `push_iq` and adds one to `cnt_dispatched`.
- R10: Flags are checked in a fixed priority: squashed, then the full check, then load, store, non-speculative, and finally nop or executed. Per slot, at most one of `push_iq`, `push_nsq` and `tail_adv` is set.
- R11: Every routed slot claims exactly one queue entry, whichever destination it takes. The number of routed slots in a cycle never exceeds `iq_free`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| grp_count | input | $clog2(W+1) | Number of valid slots in the group |
| slot_flags | input | 6*W | Per slot i, bits [6i+5:6i]: squashed, load, store, non-spec, nop, executed (bit 0 first) |
| iq_free | input | $clog2(IQ_DEPTH+1) | Free instruction-queue entries |
| push_iq | output | W | Write slot into instruction queue |
| push_lsq | output | W | Write slot into load/store queue |
| push_nsq | output | W | Write slot into non-speculative queue |
| can_commit | output | W | Slot marked ready to commit |
| mark_issued | output | W | Slot marked issued |
| tail_adv | output | W | Slot only advances the queue tail |
| stall | output | 1 | Stall to rename: queue full inside this group |
| replay | output | W | Valid slots not processed this cycle |
| cnt_squashed | output | CNT_W | Squashed slots dropped |
| cnt_full | output | CNT_W | Queue-full events |
| cnt_dispatched | output | CNT_W | Slots inserted in the instruction queue |
| cnt_load | output | CNT_W | Loads dispatched |
| cnt_store | output | CNT_W | Stores dispatched |
| cnt_nonspec | output | CNT_W | Non-speculative dispatches, stores included |

## Verification
The bench builds the block with `W` = 4 and `IQ_DEPTH` = 8. With these values the free count can be lower than, equal to or higher than the group size. This puts the stall point within reach at each slot position, including slot 0 when `iq_free` is zero, and also covers an exact fit that does not stall. The four-slot group is wide enough for a squashed slot to come before the stall point, between routed slots, or after the stall point. It also allows groups that mix all six flag kinds together with conflicting flag pairs.

// File: rtl/dsu_pkg.sv
package dsu_pkg;

    // Per-slot flag word; bit 0 is the squashed flag.
    typedef struct packed {
        logic executed;
        logic nop;
        logic nonspec;
        logic store;
        logic load;
        logic squashed;
    } slot_flags_t;

    localparam int FLAG_BITS = $bits(slot_flags_t);

    typedef enum logic [2:0] {
        K_DROP  = 3'd0,
        K_LOAD  = 3'd1,
        K_STORE = 3'd2,
        K_NSPEC = 3'd3,
        K_TAIL  = 3'd4,
        K_IQ    = 3'd5
    } kind_e;

    typedef struct packed {
        logic to_iq;
        logic to_lsq;
        logic to_nsq;
        logic can_commit;
        logic issued;
        logic tail_adv;
    } route_t;

    // Fixed priority of the type checks.
    function automatic kind_e classify(slot_flags_t f);
        kind_e k;
        if (f.squashed)              k = K_DROP;
        else if (f.load)             k = K_LOAD;
        else if (f.store)            k = K_STORE;
        else if (f.nonspec)          k = K_NSPEC;
        else if (f.nop || f.executed) k = K_TAIL;
        else                         k = K_IQ;
        return k;
    endfunction

    function automatic route_t route_of(kind_e k);
        route_t r;
        r = '0;
        case (k)
            K_LOAD:  begin r.to_lsq = 1'b1; r.to_iq = 1'b1; end
            K_STORE: begin r.to_lsq = 1'b1; r.to_nsq = 1'b1; r.can_commit = 1'b1; end
            K_NSPEC: r.to_nsq = 1'b1;
            K_TAIL:  begin r.issued = 1'b1; r.can_commit = 1'b1; r.tail_adv = 1'b1; end
            K_IQ:    r.to_iq = 1'b1;
            default: r = '0;
        endcase
        return r;
    endfunction

endpackage

// File: rtl/dsu_slot_decode.sv
module dsu_slot_decode
    import dsu_pkg::*;
(
    input  slot_flags_t flags,
    output kind_e       kind,
    output route_t      route
);
    always_comb begin
        kind  = classify(flags);
        route = route_of(kind);
    end
endmodule

// File: rtl/dsu_scan.sv
module dsu_scan
    import dsu_pkg::*;
#(
    parameter int W  = 4,
    parameter int CW = 3,
    parameter int FW = 5
) (
    input  logic [CW-1:0] count,
    input  logic [FW-1:0] free,
    input  kind_e         kinds [W],
    output logic [W-1:0]  routed,
    output logic [W-1:0]  dropped,
    output logic [W-1:0]  held,
    output logic          halt
);
    int   claimed;
    logic stopped;

    // Walk slots in program order; stop at the first one with no entry left.
    always_comb begin
        claimed = 0;
        stopped = 1'b0;
        routed  = '0;
        dropped = '0;
        held    = '0;
        for (int i = 0; i < W; i++) begin
            if (i < int'(count)) begin
                if (stopped) begin
                    held[i] = 1'b1;
                end else if (kinds[i] == K_DROP) begin
                    dropped[i] = 1'b1;
                end else if (claimed >= int'(free)) begin
                    stopped = 1'b1;
                    held[i] = 1'b1;
                end else begin
                    routed[i] = 1'b1;
                    claimed   = claimed + 1;
                end
            end
        end
        halt = stopped;
    end
endmodule

// File: rtl/dsu_counters.sv
module dsu_counters #(
    parameter int W     = 4,
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [W-1:0]     drop_m,
    input  logic             full_ev,
    input  logic [W-1:0]     disp_m,
    input  logic [W-1:0]     load_m,
    input  logic [W-1:0]     store_m,
    input  logic [W-1:0]     nspec_m,
    output logic [CNT_W-1:0] cnt_squashed,
    output logic [CNT_W-1:0] cnt_full,
    output logic [CNT_W-1:0] cnt_dispatched,
    output logic [CNT_W-1:0] cnt_load,
    output logic [CNT_W-1:0] cnt_store,
    output logic [CNT_W-1:0] cnt_nonspec
);
    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_squashed   <= '0;
            cnt_full       <= '0;
            cnt_dispatched <= '0;
            cnt_load       <= '0;
            cnt_store      <= '0;
            cnt_nonspec    <= '0;
        end else begin
            cnt_squashed   <= cnt_squashed   + CNT_W'($countones(drop_m));
            cnt_full       <= cnt_full       + CNT_W'(full_ev);
            cnt_dispatched <= cnt_dispatched + CNT_W'($countones(disp_m));
            cnt_load       <= cnt_load       + CNT_W'($countones(load_m));
            cnt_store      <= cnt_store      + CNT_W'($countones(store_m));
            cnt_nonspec    <= cnt_nonspec    + CNT_W'($countones(nspec_m));
        end
    end
endmodule

// File: rtl/dispatch_steer.sv
module dispatch_steer
    import dsu_pkg::*;
#(
    parameter int W        = 4,
    parameter int IQ_DEPTH = 16,
    parameter int CNT_W    = 16,
    localparam int CW      = $clog2(W + 1),
    localparam int FW      = $clog2(IQ_DEPTH + 1)
) (
    input  logic                   clk,
    input  logic                   rst,
    input  logic [CW-1:0]          grp_count,
    input  logic [W*FLAG_BITS-1:0] slot_flags,
    input  logic [FW-1:0]          iq_free,
    output logic [W-1:0]           push_iq,
    output logic [W-1:0]           push_lsq,
    output logic [W-1:0]           push_nsq,
    output logic [W-1:0]           can_commit,
    output logic [W-1:0]           mark_issued,
    output logic [W-1:0]           tail_adv,
    output logic                   stall,
    output logic [W-1:0]           replay,
    output logic [CNT_W-1:0]       cnt_squashed,
    output logic [CNT_W-1:0]       cnt_full,
    output logic [CNT_W-1:0]       cnt_dispatched,
    output logic [CNT_W-1:0]       cnt_load,
    output logic [CNT_W-1:0]       cnt_store,
    output logic [CNT_W-1:0]       cnt_nonspec
);
    kind_e        kinds [W];
    route_t       routes [W];
    logic [W-1:0] routed, dropped;
    logic [W-1:0] disp_m, load_m, store_m, nspec_m;

    for (genvar i = 0; i < W; i++) begin : g_slot
        dsu_slot_decode u_dec (
            .flags (slot_flags_t'(slot_flags[i*FLAG_BITS +: FLAG_BITS])),
            .kind  (kinds[i]),
            .route (routes[i])
        );
        assign push_iq[i]     = routed[i] & routes[i].to_iq;
        assign push_lsq[i]    = routed[i] & routes[i].to_lsq;
        assign push_nsq[i]    = routed[i] & routes[i].to_nsq;
        assign can_commit[i]  = routed[i] & routes[i].can_commit;
        assign mark_issued[i] = routed[i] & routes[i].issued;
        assign tail_adv[i]    = routed[i] & routes[i].tail_adv;
        assign load_m[i]      = routed[i] & (kinds[i] == K_LOAD);
        assign store_m[i]     = routed[i] & (kinds[i] == K_STORE);
        assign disp_m[i]      = routed[i] & ((kinds[i] == K_IQ) | (kinds[i] == K_LOAD));
        assign nspec_m[i]     = routed[i] & ((kinds[i] == K_NSPEC) | (kinds[i] == K_STORE));

        AST_ROUTE_EXCL: assert property (@(posedge clk) disable iff (rst)
            $onehot0({push_iq[i], push_nsq[i], tail_adv[i]}));  // R10
    end

    dsu_scan #(.W(W), .CW(CW), .FW(FW)) u_scan (
        .count   (grp_count),
        .free    (iq_free),
        .kinds   (kinds),
        .routed  (routed),
        .dropped (dropped),
        .held    (replay),
        .halt    (stall)
    );

    dsu_counters #(.W(W), .CNT_W(CNT_W)) u_cnt (
        .clk            (clk),
        .rst            (rst),
        .drop_m         (dropped),
        .full_ev        (stall),
        .disp_m         (disp_m),
        .load_m         (load_m),
        .store_m        (store_m),
        .nspec_m        (nspec_m),
        .cnt_squashed   (cnt_squashed),
        .cnt_full       (cnt_full),
        .cnt_dispatched (cnt_dispatched),
        .cnt_load       (cnt_load),
        .cnt_store      (cnt_store),
        .cnt_nonspec    (cnt_nonspec)
    );

    AST_CLAIM_BOUND: assert property (@(posedge clk) disable iff (rst)
        $countones(push_iq | push_nsq | tail_adv) <= int'(iq_free));  // R11

    AST_IN_GROUP: assert property (@(posedge clk) disable iff (rst)
        ((push_iq | push_lsq | push_nsq | tail_adv | replay) >> grp_count) == '0);  // R2

    AST_STALL_REPLAY: assert property (@(posedge clk) disable iff (rst)
        stall == (replay != '0));  // R4

    AST_FULL_STEP: assert property (@(posedge clk) disable iff (rst)
        $past(!rst && stall) |-> cnt_full == $past(cnt_full) + CNT_W'(1));  // R4

endmodule

// File: tb/dispatch_steer_bench.sv
module dispatch_steer_bench;
    localparam int W = 4;
    localparam int IQ_DEPTH = 8;
    localparam int CNT_W = 16;
    localparam int CW = $clog2(W + 1);
    localparam int FW = $clog2(IQ_DEPTH + 1);

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic [CW-1:0]  grp_count = '0;
    logic [W*6-1:0] slot_flags = '0;
    logic [FW-1:0]  iq_free = '0;
    logic [W-1:0] push_iq, push_lsq, push_nsq, can_commit, mark_issued, tail_adv, replay;
    logic stall;
    logic [CNT_W-1:0] cnt_squashed, cnt_full, cnt_dispatched, cnt_load, cnt_store, cnt_nonspec;

    always #5 clk = ~clk;

    dispatch_steer #(.W(W), .IQ_DEPTH(IQ_DEPTH), .CNT_W(CNT_W)) u_dispatch_steer (
        .clk(clk), .rst(rst), .grp_count(grp_count), .slot_flags(slot_flags), .iq_free(iq_free),
        .push_iq(push_iq), .push_lsq(push_lsq), .push_nsq(push_nsq), .can_commit(can_commit),
        .mark_issued(mark_issued), .tail_adv(tail_adv), .stall(stall), .replay(replay),
        .cnt_squashed(cnt_squashed), .cnt_full(cnt_full), .cnt_dispatched(cnt_dispatched),
        .cnt_load(cnt_load), .cnt_store(cnt_store), .cnt_nonspec(cnt_nonspec)
    );

    typedef struct {
        logic [W-1:0] iq, lsq, nsq, cc, iss, tail, rep;
        logic         stl;
        int           c_sq, c_full, c_disp, c_ld, c_st, c_ns;
    } exp_t;

    exp_t scb [$];
    int tests = 0;
    int fails = 0;
    int r_sq = 0, r_full = 0, r_disp = 0, r_ld = 0, r_st = 0, r_ns = 0;

    // Flag bits per slot: 0 squashed, 1 load, 2 store, 3 nonspec, 4 nop, 5 executed
    localparam logic [5:0] F_PL = 6'h00, F_SQ = 6'h01, F_LD = 6'h02, F_ST = 6'h04,
                           F_NS = 6'h08, F_NOP = 6'h10, F_EX = 6'h20;

    task automatic chk(string req, string what, int act, int exp);
        tests++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    // Driver: apply one group and push the expected outcome
    task automatic send(int cnt, logic [W*6-1:0] fl, int fr);
        exp_t e;
        int used;
        bit halted;
        logic [5:0] f;
        @(negedge clk);
        grp_count  = CW'(cnt);
        slot_flags = fl;
        iq_free    = FW'(fr);
        e.iq = '0; e.lsq = '0; e.nsq = '0; e.cc = '0; e.iss = '0; e.tail = '0; e.rep = '0;
        e.stl = 1'b0;
        e.c_sq = r_sq; e.c_full = r_full; e.c_disp = r_disp;
        e.c_ld = r_ld; e.c_st = r_st; e.c_ns = r_ns;
        used = 0; halted = 0;
        for (int i = 0; i < cnt && i < W; i++) begin
            f = fl[i*6 +: 6];
            if (halted) e.rep[i] = 1'b1;
            else if (f[0]) r_sq++;
            else if (used == fr) begin
                halted = 1; e.rep[i] = 1'b1; e.stl = 1'b1; r_full++;
            end else begin
                used++;
                if (f[1]) begin e.lsq[i] = 1; e.iq[i] = 1; r_ld++; r_disp++; end
                else if (f[2]) begin e.lsq[i] = 1; e.nsq[i] = 1; e.cc[i] = 1; r_st++; r_ns++; end
                else if (f[3]) begin e.nsq[i] = 1; r_ns++; end
                else if (f[4] || f[5]) begin e.iss[i] = 1; e.cc[i] = 1; e.tail[i] = 1; end
                else begin e.iq[i] = 1; r_disp++; end
            end
        end
        scb.push_back(e);
    endtask

    // Monitor: compare just before the next rising edge
    initial begin
        exp_t e;
        forever begin
            @(negedge clk);
            #3;
            if (scb.size() > 0) begin
                e = scb.pop_front();
                chk("R9", "push_iq", int'(push_iq), int'(e.iq));
                chk("R5", "push_lsq", int'(push_lsq), int'(e.lsq));
                chk("R7", "push_nsq", int'(push_nsq), int'(e.nsq));
                chk("R6", "can_commit", int'(can_commit), int'(e.cc));
                chk("R8", "mark_issued", int'(mark_issued), int'(e.iss));
                chk("R8", "tail_adv", int'(tail_adv), int'(e.tail));
                chk("R4", "stall", int'(stall), int'(e.stl));
                chk("R4", "replay", int'(replay), int'(e.rep));
                chk("R3", "cnt_squashed", int'(cnt_squashed), e.c_sq);
                chk("R4", "cnt_full", int'(cnt_full), e.c_full);
                chk("R9", "cnt_dispatched", int'(cnt_dispatched), e.c_disp);
                chk("R5", "cnt_load", int'(cnt_load), e.c_ld);
                chk("R6", "cnt_store", int'(cnt_store), e.c_st);
                chk("R7", "cnt_nonspec", int'(cnt_nonspec), e.c_ns);
            end
        end
    end

    initial begin
        repeat (100000) @(posedge clk);
        fails++;
        $display("FAIL watchdog expired actual=running expected=done");
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        // R1: counters cleared by reset
        chk("R1", "cnt_squashed", int'(cnt_squashed), 0);
        chk("R1", "cnt_full", int'(cnt_full), 0);
        chk("R1", "cnt_dispatched", int'(cnt_dispatched), 0);
        chk("R1", "cnt_nonspec", int'(cnt_nonspec), 0);

        send(4, {F_PL, F_PL, F_PL, F_PL}, 8);            // R9 plain group
        send(4, {F_NOP, F_NS, F_ST, F_LD}, 8);           // R5 R6 R7 R8 one of each
        send(4, {F_EX, F_NOP|F_NS, F_ST|F_NS, F_LD|F_ST}, 8); // R10 priority
        send(3, {F_PL, F_SQ, F_SQ|F_LD, F_PL}, 8);       // R3 squashed drops
        send(4, {F_PL, F_PL, F_PL, F_PL}, 2);            // R4 R11 stall at slot 2
        send(4, {F_LD, F_PL, F_PL, F_PL}, 0);            // R4 stall at slot 0
        send(4, {F_PL, F_PL, F_PL, F_SQ}, 1);            // R11 squashed claims nothing
        send(2, {F_LD, F_ST, F_PL, F_NS}, 8);            // R2 slots beyond count ignored
        send(0, {F_LD, F_LD, F_LD, F_LD}, 8);            // R2 empty group
        send(3, {F_PL, F_ST, F_NOP, F_PL}, 3);           // R11 exact fit, no stall
        send(4, {F_SQ, F_SQ, F_PL, F_PL}, 1);            // R3 R4 squashed after stop not counted
        send(4, {F_SQ, F_SQ, F_SQ, F_SQ}, 0);            // R3 all squashed, no stall with zero free
        for (int n = 0; n < 300; n++) begin
            logic [W*6-1:0] fl;
            for (int s = 0; s < W; s++) begin
                int pick = $urandom_range(0, 9);
                fl[s*6 +: 6] = (pick < 6) ? 6'(1 << pick) : ((pick == 9) ? 6'($urandom_range(0, 63)) : 6'h00);
            end
            send($urandom_range(0, W), fl, $urandom_range(0, IQ_DEPTH));
        end
        send(0, '0, 8);
        @(negedge clk);
        #3;
        chk("R4", "final cnt_full", int'(cnt_full), r_full);
        chk("R3", "final cnt_squashed", int'(cnt_squashed), r_sq);
        chk("R9", "final cnt_dispatched", int'(cnt_dispatched), r_disp);
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule